// File: doc/BRIEF.md
# Character LCD Nibble-Bus Controller

This block talks to a character LCD controller over a 4-bit parallel bus with a register-select line, a read/write line and an enable strobe. After reset it runs the power-up handshake on its own: a long settling wait, a train of raw mode nibbles spaced by fixed waits, and then a short list of setup instructions. Once that is done it accepts byte requests, each tagged as an instruction or as display data. It sends every byte as two nibbles, high nibble first.

Before any byte is written the block reads the display's status byte and repeats the read until the busy flag is clear. Pacing therefore follows the display's real state rather than worst-case delays. The data pins are split into an output nibble, an input nibble and an output enable, so that the pad ring can build the bidirectional pins. Every bus timing and every handshake wait is a parameter in nanoseconds, converted to clock cycles from the clock frequency parameter.

Top module: `lcd4_ctrl`

## Requirements
- R1: While reset is high and afterwards until the startup list has finished, `req_ready` stays low, and the enable strobe is low during reset with the data output enable high.
- R2: The first enable pulse after reset comes no earlier than the power-up wait (default 40 ms). It is a write (R/W low) of nibble 0x3 with RS low.
- R3: The raw handshake writes nibbles 0x3, 0x3, 0x3, 0x2 with RS low and no status reads in between. From the fall of each nibble's enable to the next enable rise the gap is at least 4.1 ms, 100 us, 37 us and 37 us in turn.
- R4: After the raw handshake, the instructions 0x20, 0x08, 0x01 and 0x06 are written in that order, each through the busy-checked path.
- R5: A byte is sent as its bits 7..4 first and then its bits 3..0, on DB7..DB4, each nibble latched by the falling edge of the enable strobe.
- R6: Before each byte write the block reads the status byte as two nibbles with RS low and R/W high. If bit 7 of that byte (bit 3 of the first nibble) is 1, it reads the whole status byte again. It writes only after reading a 0 there.
- R7: RS is high when writing a data request and low when writing an instruction request or reading status. R/W is low for writes and high for reads.
- R8: The data output enable is low whenever R/W is high and high whenever R/W is low. RS, R/W and the output enable are set at least the address setup time (default 40 ns, at least one cycle) before the enable rises.
- R9: The enable stays high for at least the pulse width (default 450 ns). Rises of the enable are at least the cycle time (default 500 ns) apart. RS, R/W and the output nibble do not change while the enable is high.
- R10: A status nibble is sampled while the enable is still high, at the end of the pulse width, which also covers the 360 ns read access time.
- R11: `req_ready` is high only when the controller is idle after the startup list. A request is taken when `req_valid` and `req_ready` are both high at a clock edge, `req_ready` then falls for the next cycle, and it returns only after that byte's write completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A byte request is offered |
| req_is_data | input | 1 | 1 = display data, 0 = instruction |
| req_byte | input | 8 | Byte to write |
| req_ready | output | 1 | Controller can take a request |
| lcd_rs | output | 1 | Register select (1 = data) |
| lcd_rw | output | 1 | Bus direction (1 = read) |
| lcd_e | output | 1 | Enable strobe |
| lcd_db_out | output | 4 | Nibble driven onto DB7..DB4 |
| lcd_db_in | input | 4 | Nibble read from DB7..DB4 |
| lcd_db_oe | output | 1 | Output enable for DB7..DB4 |

## Verification
On every cycle the bound checker watches the pin-level rules. These are the output-enable versus R/W pairing, control lines held steady across the enable rise and throughout the enable pulse, the minimum enable high time, a quiet bus while ready, and ready dropping after a taken request. The order of the handshake nibbles, the millisecond gaps, the init instruction list, the nibble order and the number of status polls per byte can only be shown by the bench. It uses a display model that reports the busy flag for a chosen number of status reads and records every enable pulse. The same model shows that the status nibble is taken while the enable is high, because it drives the busy flag only during the read pulse.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

  // Round a duration up to whole clock cycles, never less than one.
  function automatic int unsigned ns_to_cyc(input longint unsigned hz,
                                            input longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_SETUP,
    BUS_EHIGH,
    BUS_ELOW
  } bus_state_t;

  typedef enum logic [2:0] {
    SQ_PWR,
    SQ_RAW,
    SQ_RAW_GAP,
    SQ_POLL_HI,
    SQ_POLL_LO,
    SQ_WR_HI,
    SQ_WR_LO,
    SQ_IDLE
  } seq_state_t;

endpackage

// File: rtl/lcd4_delay.sv
module lcd4_delay #(
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] count,
  output logic          expired
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= count;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/lcd4_nibble_bus.sv
module lcd4_nibble_bus import lcd4_pkg::*; #(
  parameter int unsigned T_AS   = 1,
  parameter int unsigned T_PW   = 1,
  parameter int unsigned T_REST = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       rd,
  input  logic       rs_in,
  input  logic [3:0] wnib,
  output logic       done,
  output logic [3:0] rnib,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [3:0] lcd_dout,
  output logic       lcd_oe,
  input  logic [3:0] lcd_din
);
  localparam int unsigned CW = $clog2(T_AS + T_PW + T_REST + 1);

  bus_state_t     st;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BUS_IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      rnib     <= '0;
      lcd_rs   <= 1'b0;
      lcd_rw   <= 1'b0;
      lcd_e    <= 1'b0;
      lcd_dout <= '0;
      lcd_oe   <= 1'b1;
    end else begin
      done <= 1'b0;
      case (st)
        BUS_IDLE: begin
          if (go) begin
            lcd_rs <= rs_in;
            lcd_rw <= rd;
            lcd_oe <= ~rd;
            if (!rd) lcd_dout <= wnib;
            cnt <= CW'(T_AS - 1);
            st  <= BUS_SETUP;
          end
        end
        BUS_SETUP: begin
          if (cnt == '0) begin
            lcd_e <= 1'b1;
            cnt   <= CW'(T_PW - 1);
            st    <= BUS_EHIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BUS_EHIGH: begin
          if (cnt == '0) begin
            lcd_e <= 1'b0;
            if (lcd_rw) rnib <= lcd_din;
            cnt <= CW'(T_REST - 1);
            st  <= BUS_ELOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BUS_ELOW: begin
          if (cnt == '0) begin
            done <= 1'b1;
            st   <= BUS_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= BUS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd4_seq.sv
module lcd4_seq import lcd4_pkg::*; #(
  parameter int unsigned DW    = 24,
  parameter int unsigned C_PWR = 100,
  parameter int unsigned C_G1  = 10,
  parameter int unsigned C_G2  = 10,
  parameter int unsigned C_G3  = 10,
  parameter int unsigned C_G4  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_is_data,
  input  logic [7:0]    req_byte,
  output logic          req_ready,
  output logic          bus_go,
  output logic          bus_rd,
  output logic          bus_rs,
  output logic [3:0]    bus_wnib,
  input  logic          bus_done,
  input  logic [3:0]    bus_rnib,
  output logic          dly_load,
  output logic [DW-1:0] dly_count,
  input  logic          dly_zero
);
  localparam int unsigned RAW_LAST  = 3;
  localparam int unsigned INIT_LEN  = 4;

  seq_state_t  state;
  logic        launched;
  logic [1:0]  raw_idx;
  logic [2:0]  init_idx;
  logic [7:0]  cur_byte;
  logic        cur_rs;
  logic        bf_q;
  logic [2:0]  stat_unused;

  assign stat_unused = bus_rnib[2:0];

  function automatic logic [7:0] init_byte(input logic [1:0] i);
    case (i)
      2'd0:    return 8'h20;
      2'd1:    return 8'h08;
      2'd2:    return 8'h01;
      default: return 8'h06;
    endcase
  endfunction

  always_comb begin
    bus_go    = 1'b0;
    bus_rd    = 1'b0;
    bus_rs    = 1'b0;
    bus_wnib  = cur_byte[3:0];
    dly_load  = 1'b0;
    dly_count = DW'(C_PWR);
    case (state)
      SQ_PWR: dly_load = ~launched;
      SQ_RAW: begin
        bus_go   = ~launched;
        bus_wnib = (raw_idx == 2'(RAW_LAST)) ? 4'h2 : 4'h3;
      end
      SQ_RAW_GAP: begin
        dly_load = ~launched;
        case (raw_idx)
          2'd0:    dly_count = DW'(C_G1);
          2'd1:    dly_count = DW'(C_G2);
          2'd2:    dly_count = DW'(C_G3);
          default: dly_count = DW'(C_G4);
        endcase
      end
      SQ_POLL_HI, SQ_POLL_LO: begin
        bus_go = ~launched;
        bus_rd = 1'b1;
      end
      SQ_WR_HI: begin
        bus_go   = ~launched;
        bus_rs   = cur_rs;
        bus_wnib = cur_byte[7:4];
      end
      SQ_WR_LO: begin
        bus_go = ~launched;
        bus_rs = cur_rs;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_PWR;
      launched  <= 1'b0;
      raw_idx   <= '0;
      init_idx  <= '0;
      cur_byte  <= '0;
      cur_rs    <= 1'b0;
      bf_q      <= 1'b0;
      req_ready <= 1'b0;
    end else begin
      case (state)
        SQ_PWR: begin
          if (!launched) launched <= 1'b1;
          else if (dly_zero) begin
            launched <= 1'b0;
            state    <= SQ_RAW;
          end
        end
        SQ_RAW: begin
          if (!launched) launched <= 1'b1;
          else if (bus_done) begin
            launched <= 1'b0;
            state    <= SQ_RAW_GAP;
          end
        end
        SQ_RAW_GAP: begin
          if (!launched) launched <= 1'b1;
          else if (dly_zero) begin
            launched <= 1'b0;
            if (raw_idx == 2'(RAW_LAST)) begin
              cur_byte <= init_byte(2'd0);
              cur_rs   <= 1'b0;
              init_idx <= 3'd1;
              state    <= SQ_POLL_HI;
            end else begin
              raw_idx <= raw_idx + 1'b1;
              state   <= SQ_RAW;
            end
          end
        end
        SQ_POLL_HI: begin
          if (!launched) launched <= 1'b1;
          else if (bus_done) begin
            launched <= 1'b0;
            bf_q     <= bus_rnib[3];
            state    <= SQ_POLL_LO;
          end
        end
        SQ_POLL_LO: begin
          if (!launched) launched <= 1'b1;
          else if (bus_done) begin
            launched <= 1'b0;
            state    <= bf_q ? SQ_POLL_HI : SQ_WR_HI;
          end
        end
        SQ_WR_HI: begin
          if (!launched) launched <= 1'b1;
          else if (bus_done) begin
            launched <= 1'b0;
            state    <= SQ_WR_LO;
          end
        end
        SQ_WR_LO: begin
          if (!launched) launched <= 1'b1;
          else if (bus_done) begin
            launched <= 1'b0;
            if (init_idx != 3'(INIT_LEN)) begin
              cur_byte <= init_byte(init_idx[1:0]);
              cur_rs   <= 1'b0;
              init_idx <= init_idx + 1'b1;
              state    <= SQ_POLL_HI;
            end else begin
              req_ready <= 1'b1;
              state     <= SQ_IDLE;
            end
          end
        end
        SQ_IDLE: begin
          if (req_valid && req_ready) begin
            cur_byte  <= req_byte;
            cur_rs    <= req_is_data;
            req_ready <= 1'b0;
            state     <= SQ_POLL_HI;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd4_ctrl.sv
module lcd4_ctrl import lcd4_pkg::*; #(
  parameter longint unsigned CLK_HZ     = 125_000_000,
  parameter longint unsigned T_PWRUP_NS = 40_000_000,
  parameter longint unsigned T_GAP1_NS  = 4_100_000,
  parameter longint unsigned T_GAP2_NS  = 100_000,
  parameter longint unsigned T_GAP3_NS  = 37_000,
  parameter longint unsigned T_GAP4_NS  = 37_000,
  parameter longint unsigned T_ASU_NS   = 40,
  parameter longint unsigned T_EPW_NS   = 450,
  parameter longint unsigned T_ECYC_NS  = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_is_data,
  input  logic [7:0] req_byte,
  output logic       req_ready,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [3:0] lcd_db_out,
  input  logic [3:0] lcd_db_in,
  output logic       lcd_db_oe
);
  localparam int unsigned C_PWR  = ns_to_cyc(CLK_HZ, T_PWRUP_NS);
  localparam int unsigned C_G1   = ns_to_cyc(CLK_HZ, T_GAP1_NS);
  localparam int unsigned C_G2   = ns_to_cyc(CLK_HZ, T_GAP2_NS);
  localparam int unsigned C_G3   = ns_to_cyc(CLK_HZ, T_GAP3_NS);
  localparam int unsigned C_G4   = ns_to_cyc(CLK_HZ, T_GAP4_NS);
  localparam int unsigned C_AS   = ns_to_cyc(CLK_HZ, T_ASU_NS);
  localparam int unsigned C_PW   = ns_to_cyc(CLK_HZ, T_EPW_NS);
  localparam int unsigned C_CYC  = ns_to_cyc(CLK_HZ, T_ECYC_NS);
  localparam int unsigned C_REST = (C_CYC > C_PW) ? (C_CYC - C_PW) : 1;
  localparam int unsigned DW     = $clog2(C_PWR + C_G1 + C_G2 + C_G3 + C_G4 + 1);

  logic          bus_go, bus_rd, bus_rs, bus_done;
  logic [3:0]    bus_wnib, bus_rnib;
  logic          dly_load, dly_zero;
  logic [DW-1:0] dly_count;

  lcd4_seq #(
    .DW(DW), .C_PWR(C_PWR), .C_G1(C_G1), .C_G2(C_G2), .C_G3(C_G3), .C_G4(C_G4)
  ) i_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_is_data(req_is_data), .req_byte(req_byte),
    .req_ready(req_ready),
    .bus_go(bus_go), .bus_rd(bus_rd), .bus_rs(bus_rs), .bus_wnib(bus_wnib),
    .bus_done(bus_done), .bus_rnib(bus_rnib),
    .dly_load(dly_load), .dly_count(dly_count), .dly_zero(dly_zero)
  );

  lcd4_delay #(.DW(DW)) i_delay (
    .clk(clk), .rst(rst), .load(dly_load), .count(dly_count), .expired(dly_zero)
  );

  lcd4_nibble_bus #(.T_AS(C_AS), .T_PW(C_PW), .T_REST(C_REST)) i_bus (
    .clk(clk), .rst(rst),
    .go(bus_go), .rd(bus_rd), .rs_in(bus_rs), .wnib(bus_wnib),
    .done(bus_done), .rnib(bus_rnib),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
    .lcd_dout(lcd_db_out), .lcd_oe(lcd_db_oe), .lcd_din(lcd_db_in)
  );
endmodule

// File: rtl/lcd4_ctrl_chk.sv
module lcd4_ctrl_chk #(
  parameter int unsigned MIN_E_HIGH = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_e,
  input logic [3:0] lcd_db_out,
  input logic       lcd_db_oe
);
  logic [31:0] e_len;

  always_ff @(posedge clk) begin
    if (rst)        e_len <= '0;
    else if (lcd_e) e_len <= e_len + 1'b1;
    else            e_len <= '0;
  end

  AST_OE_OFF_ON_READ: assert property (@(posedge clk) disable iff (rst)
    lcd_rw |-> !lcd_db_oe); // R8
  AST_OE_ON_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !lcd_rw |-> lcd_db_oe); // R8
  AST_CTRL_SETUP: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_oe))); // R8
  AST_HOLD_WHILE_E: assert property (@(posedge clk) disable iff (rst)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_out))); // R9
  AST_E_MIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_e) |-> (e_len >= MIN_E_HIGH)); // R9
  AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !lcd_e); // R11
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R11
endmodule

bind lcd4_ctrl lcd4_ctrl_chk #(.MIN_E_HIGH(C_PW)) i_lcd4_ctrl_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
  .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe)
);

// File: tb/test_lcd4_ctrl.sv
`timescale 1ns/1ps
module test_lcd4_ctrl;
  // 10 MHz nominal timing: 100 ns per cycle for the bus rules.
  localparam int E_PW_C  = 5;     // 450 ns
  localparam int E_CYC_C = 5;     // 500 ns
  localparam int PWR_C   = 4000;  // 400 us shortened power-up wait
  localparam int GAP1_C  = 410;   // 41 us shortened
  localparam int GAP2_C  = 1000;  // 100 us
  localparam int GAP3_C  = 370;   // 37 us
  localparam int GAP4_C  = 370;   // 37 us

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_is_data = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic       req_ready, lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
  logic [3:0] lcd_db_out, lcd_db_in;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lcd4_ctrl #(
    .CLK_HZ(10_000_000), .T_PWRUP_NS(400_000), .T_GAP1_NS(41_000)
  ) i_lcd4_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_data(req_is_data),
    .req_byte(req_byte), .req_ready(req_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_e(lcd_e), .lcd_db_out(lcd_db_out), .lcd_db_in(lcd_db_in),
    .lcd_db_oe(lcd_db_oe)
  );

  // ---------------- display model ----------------
  int   cyc, rise_c, n_ev, n_wr, busy_left, busy_cfg;
  bit   wr_half, rd_half, need_load;
  int   setup_bad, hold_bad, pw_bad, cyc_bad, oe_bad;
  logic prev_e, prev_rs, prev_rw, prev_oe;
  logic [3:0] prev_dout;
  bit   ev_wr [256];
  bit   ev_rs [256];
  logic [3:0] ev_nib [256];
  int   ev_rise [256];
  int   ev_fall [256];

  assign lcd_db_in = (lcd_e && lcd_rw) ?
                     (rd_half ? 4'h7 : {(busy_left != 0), 3'b101}) : 4'h0;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; n_ev = 0; n_wr = 0; busy_left = 0;
      wr_half = 0; rd_half = 0; need_load = 1;
      setup_bad = 0; hold_bad = 0; pw_bad = 0; cyc_bad = 0; oe_bad = 0;
    end else begin
      cyc++;
      if (lcd_e && !prev_e) begin
        if (lcd_rs !== prev_rs || lcd_rw !== prev_rw || lcd_db_oe !== prev_oe) setup_bad++;
        if (lcd_db_oe !== !lcd_rw) oe_bad++;
        if (n_ev > 0 && cyc - ev_rise[n_ev-1] < E_CYC_C) cyc_bad++;
        if (lcd_rw && !rd_half && need_load) begin
          busy_left = busy_cfg;
          need_load = 0;
        end
        rise_c = cyc;
      end
      if (lcd_e && prev_e &&
          (lcd_rs !== prev_rs || lcd_rw !== prev_rw || lcd_db_out !== prev_dout)) hold_bad++;
      if (!lcd_e && prev_e && n_ev < 256) begin
        if (cyc - rise_c < E_PW_C) pw_bad++;
        ev_wr[n_ev]   = !prev_rw;
        ev_rs[n_ev]   = prev_rs;
        ev_nib[n_ev]  = prev_rw ? 4'h0 : prev_dout;
        ev_rise[n_ev] = rise_c;
        ev_fall[n_ev] = cyc;
        n_ev++;
        if (!prev_rw) begin
          n_wr++;
          if (n_wr > 4) begin
            if (wr_half) need_load = 1;
            wr_half = !wr_half;
          end
        end else begin
          if (rd_half && busy_left > 0) busy_left--;
          rd_half = !rd_half;
        end
      end
      prev_e = lcd_e; prev_rs = lcd_rs; prev_rw = lcd_rw;
      prev_oe = lcd_db_oe; prev_dout = lcd_db_out;
    end
  end

  // ---------------- helpers ----------------
  int rd_ptr = 0;

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    tick();
    while (!req_ready) tick();
  endtask

  // Consumes one busy-checked byte from the event log.
  task automatic expect_byte(input int busy_n, input bit rs, input logic [7:0] b,
                             input string req);
    for (int p = 0; p <= busy_n; p++) begin
      for (int h = 0; h < 2; h++) begin
        chk(rd_ptr < n_ev && !ev_wr[rd_ptr] && !ev_rs[rd_ptr], "R6",
            "status read (wr*2+rs)", ev_wr[rd_ptr] * 2 + ev_rs[rd_ptr], 0);
        rd_ptr++;
      end
    end
    for (int h = 0; h < 2; h++) begin
      logic [3:0] en;
      en = h ? b[3:0] : b[7:4];
      chk(rd_ptr < n_ev && ev_wr[rd_ptr] && ev_rs[rd_ptr] == rs && ev_nib[rd_ptr] == en,
          req, h ? "low nibble write (wr*32+rs*16+nib)" : "high nibble write (wr*32+rs*16+nib)",
          ev_wr[rd_ptr] * 32 + ev_rs[rd_ptr] * 16 + int'(ev_nib[rd_ptr]),
          32 + rs * 16 + int'(en));
      rd_ptr++;
    end
  endtask

  task automatic send(input bit is_data, input logic [7:0] b);
    while (!req_ready) tick();
    req_valid = 1'b1; req_is_data = is_data; req_byte = b;
    tick();
    req_valid = 1'b0;
    chk(!req_ready, "R11", "ready after accept", req_ready, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    tick();
    chk(!req_ready, "R1", "ready in reset", req_ready, 0);
    chk(!lcd_e, "R1", "E in reset", lcd_e, 0);
    chk(lcd_db_oe, "R1", "oe in reset", lcd_db_oe, 1);
  endtask

  // Request held valid from reset; it must wait for the startup list (R1, R11).
  task automatic t_init();
    logic [3:0] raw [4] = '{4'h3, 4'h3, 4'h3, 4'h2};
    int gaps [4] = '{GAP1_C, GAP2_C, GAP3_C, GAP4_C};
    wait_ready();
    chk(n_ev == 28, "R1", "bus pulses before first ready", n_ev, 28);
    chk(ev_rise[0] >= PWR_C, "R2", "first E rise cycle", ev_rise[0], PWR_C);
    for (int i = 0; i < 4; i++) begin
      chk(ev_wr[i] && !ev_rs[i] && ev_nib[i] == raw[i], i == 0 ? "R2" : "R3",
          "raw nibble (wr*32+rs*16+nib)",
          ev_wr[i] * 32 + ev_rs[i] * 16 + int'(ev_nib[i]), 32 + int'(raw[i]));
      chk(ev_rise[i+1] - ev_fall[i] >= gaps[i], "R3", "raw gap cycles",
          ev_rise[i+1] - ev_fall[i], gaps[i]);
    end
    rd_ptr = 4;
    expect_byte(1, 0, 8'h20, "R4");
    expect_byte(1, 0, 8'h08, "R4");
    expect_byte(1, 0, 8'h01, "R4");
    expect_byte(1, 0, 8'h06, "R4");
    tick();
    chk(!req_ready, "R11", "held request taken on ready", req_ready, 0);
    req_valid = 1'b0;
    wait_ready();
    expect_byte(1, 1, 8'h41, "R7");
  endtask

  task automatic t_instr();
    busy_cfg = 0;
    send(1'b0, 8'h5A);
    wait_ready();
    expect_byte(0, 0, 8'h5A, "R5");
  endtask

  // Busy flag held for three status bytes; it is only visible while E is high (R10).
  task automatic t_busy_data();
    busy_cfg = 3;
    send(1'b1, 8'hC3);
    wait_ready();
    expect_byte(3, 1, 8'hC3, "R10");
  endtask

  task automatic t_edges();
    busy_cfg = 0;
    send(1'b1, 8'h00);
    wait_ready();
    expect_byte(0, 1, 8'h00, "R7");
    send(1'b0, 8'hFF);
    wait_ready();
    expect_byte(0, 0, 8'hFF, "R5");
    chk(rd_ptr == n_ev, "R6", "no extra bus pulses", n_ev, rd_ptr);
  endtask

  task automatic t_timing();
    chk(setup_bad == 0, "R8", "control change at E rise", setup_bad, 0);
    chk(oe_bad == 0, "R8", "oe/rw mismatch at E rise", oe_bad, 0);
    chk(hold_bad == 0, "R9", "change while E high", hold_bad, 0);
    chk(pw_bad == 0, "R9", "E pulse too short", pw_bad, 0);
    chk(cyc_bad == 0, "R9", "E cycle too short", cyc_bad, 0);
  endtask

  initial begin
    busy_cfg = 1;
    req_valid = 1'b1; req_is_data = 1'b1; req_byte = 8'h41;
    repeat (4) tick();
    t_reset();
    rst = 1'b0;
    t_init();
    t_instr();
    t_busy_data();
    t_edges();
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule